// File: doc/BRIEF.md
# Two-Wire Bus Master Controller

This block is a register-programmed master for a two-wire serial bus (SCL clock, SDA data), both lines open-drain. Software sees five 16-bit registers on a simple select/write/read bus. It turns on the module and takes mastership through a control register. It then moves bytes by accessing a data register: a write sends a byte and a read collects the last byte while starting the next one. A pending flag, which can be routed to an interrupt output, marks the end of every byte and every lost arbitration.

Each bit on the wire takes four quarter periods. Every quarter lasts a software-chosen number of system clocks, with a floor of four. A line monitor follows START and STOP conditions on the wire and reports a busy flag. Software polls that flag before it turns the module off.

Top module: `i2c_host_ctrl`

## Requirements
- R1: After reset every register reads 0, both line enables are low (lines released) and `irq` is low.
- R2: The own-address register (byte offset 0x00) and the divider register (offset 0x04) read back what was written.
- R3: With control bit 0 (enable) set, setting control bit 2 (master) pulls SDA low while SCL is high, then pulls SCL low. Status bit 3 (bus busy) then reads 1.
- R4: In transmit direction (control bit 3 = 1), a write to the data register (offset 0x10) sends its low byte MSB first, followed by a ninth clock for the acknowledge.
- R5: Status bit 1 (pending) is set at the ninth SCL falling edge of a byte. This is 36*Q cycles after the data access is taken (+1 for the flag register), where Q = max(divider, 4).
- R6: Status bit 0 holds the acknowledge sampled from the slave on the last transmitted byte (1 = NACK).
- R7: In receive direction (control bit 3 = 0), a data-register read returns the last received byte and starts the next one. That byte is answered with ACK, or with NACK when control bit 4 is set.
- R8: Clearing the master bit, once the current byte is done, produces a STOP (SDA rises while SCL is high). The bus-busy flag then clears.
- R9: If SDA reads low while the controller releases it during a transmitted bit, the controller releases both lines. It then sets status bit 2 (arbitration lost) and the pending flag, and clears the master bit.
- R10: Writing 0 to the status register (offset 0x0C) clears the pending and arbitration-lost flags.
- R11: `irq` is high exactly when the pending flag and control bit 1 (interrupt enable) are both set.
- R12: With the enable bit clear, the master bit produces no bus activity and both lines stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (data register reads have a side effect) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | 1 pulls SCL low |
| scl_in | input | 1 | Sampled SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
A data-register access is taken at the clock edge where it is presented. The byte then runs for 36 quarter ticks of Q cycles each, and the pending flag follows one edge later. The bench counts falling clock edges from the access until `irq` rises and compares the count with 36*Q+1, allowing a single cycle of slack. START needs two quarters, so the bench waits several quarters before it checks the line enables and the busy flag. Register reads are combinational and are sampled one time unit after the falling edge. A behavioural slave on the wired lines logs received bytes, the acknowledges returned to it, and START/STOP counts. It can also hold SDA low to force an arbitration loss.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 16;
   localparam int BYTE_W = 8;
   localparam int CTL_W  = 5;

   localparam logic [ADDR_W-1:0] OFS_OWN = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_DIV = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_CTL = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_STS = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_DAT = 5'h10;

   localparam int CB_EN  = 0;
   localparam int CB_IE  = 1;
   localparam int CB_MST = 2;
   localparam int CB_TX  = 3;
   localparam int CB_NAK = 4;

   localparam int SB_NACK = 0;
   localparam int SB_PEND = 1;
   localparam int SB_ARB  = 2;
   localparam int SB_BUSY = 3;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_HOLD, ST_BYTE, ST_STOP
   } eng_st_t;
endpackage

// File: rtl/i2c_host_qtick.sv
module i2c_host_qtick #(
   parameter int DIV_W = 16,
   parameter int MIN_Q = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam logic [DIV_W-1:0] MIN_QV = DIV_W'(MIN_Q);

   logic [DIV_W-1:0] eff_q;
   logic [DIV_W-1:0] cnt;

   generate
      if (MIN_Q < 2) begin : g_bad_min
         $error("i2c_host_qtick: MIN_Q must be at least 2");
      end
      if (MIN_Q > 1) begin : g_clamp
         assign eff_q = (div < MIN_QV) ? MIN_QV : div;
      end else begin : g_raw
         assign eff_q = div;
      end
   endgenerate

   assign tick = run && (cnt == eff_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!run)     cnt <= '0;
      else if (tick)     cnt <= '0;
      else               cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/i2c_host_busmon.sv
module i2c_host_busmon (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic bus_busy
);
   logic scl_q, sda_q;
   logic saw_start, saw_stop;

   assign saw_start = scl_q && scl_in && sda_q && !sda_in;
   assign saw_stop  = scl_q && scl_in && !sda_q && sda_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         bus_busy <= 1'b0;
      end else begin
         scl_q <= scl_in;
         sda_q <= sda_in;
         if (saw_start)     bus_busy <= 1'b1;
         else if (saw_stop) bus_busy <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
   import i2c_host_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              byte_done,
   input  logic              arb_lost,
   input  logic              nack,
   input  logic              bus_busy,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic [CTL_W-1:0]  ctl,
   output logic [DIV_W-1:0]  div,
   output logic              pend,
   output logic              sts_wr,
   output logic              tx_go,
   output logic              rx_go
);
   generate
      if (DIV_W > DATA_W || DIV_W < 3) begin : g_bad_div
         $error("i2c_host_regs: DIV_W out of range");
      end
   endgenerate

   logic [DATA_W-1:0] own;
   logic              arb;
   logic              wr_hit_own, wr_hit_div, wr_hit_ctl;

   assign wr_hit_own = bus_sel && bus_wr && (bus_addr == OFS_OWN);
   assign wr_hit_div = bus_sel && bus_wr && (bus_addr == OFS_DIV);
   assign wr_hit_ctl = bus_sel && bus_wr && (bus_addr == OFS_CTL);
   assign sts_wr     = bus_sel && bus_wr && (bus_addr == OFS_STS);
   assign tx_go      = bus_sel && bus_wr && (bus_addr == OFS_DAT);
   assign rx_go      = bus_sel && bus_rd && (bus_addr == OFS_DAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own  <= '0;
         div  <= '0;
         ctl  <= '0;
         pend <= 1'b0;
         arb  <= 1'b0;
      end else begin
         if (wr_hit_own) own <= bus_wdata;
         if (wr_hit_div) div <= bus_wdata[DIV_W-1:0];
         if (wr_hit_ctl) ctl <= bus_wdata[CTL_W-1:0];
         if (arb_lost)   ctl[CB_MST] <= 1'b0;
         if (byte_done || arb_lost) pend <= 1'b1;
         else if (sts_wr)           pend <= pend & bus_wdata[SB_PEND];
         if (arb_lost)    arb <= 1'b1;
         else if (sts_wr) arb <= arb & bus_wdata[SB_ARB];
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_OWN: bus_rdata = own;
         OFS_DIV: bus_rdata = DATA_W'(div);
         OFS_CTL: bus_rdata = DATA_W'(ctl);
         OFS_STS: begin
            bus_rdata[SB_NACK] = nack;
            bus_rdata[SB_PEND] = pend;
            bus_rdata[SB_ARB]  = arb;
            bus_rdata[SB_BUSY] = bus_busy;
         end
         OFS_DAT: bus_rdata = DATA_W'(rx_byte);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/i2c_host_engine.sv
module i2c_host_engine
   import i2c_host_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              msta,
   input  logic              tx_dir,
   input  logic              tx_nak,
   input  logic              tx_go,
   input  logic              rx_go,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              tick,
   input  logic              bus_busy,
   input  logic              sda_in,
   output logic              run,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              byte_done,
   output logic              arb_lost,
   output logic              nack,
   output logic [BYTE_W-1:0] rx_byte
);
   localparam int          BIT_W = $clog2(BYTE_W + 1);
   localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_W);

   eng_st_t           state;
   logic [1:0]        phase;
   logic [BIT_W-1:0]  bitn;
   logic [BYTE_W-1:0] shreg;
   logic              rx_mode;
   logic              drive_low;

   assign run = (state == ST_START) || (state == ST_BYTE) || (state == ST_STOP);

   always_comb begin
      if (bitn == ACK_SLOT) drive_low = rx_mode ? !tx_nak : 1'b0;
      else                  drive_low = rx_mode ? 1'b0 : !shreg[BYTE_W-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         phase     <= '0;
         bitn      <= '0;
         shreg     <= '0;
         rx_mode   <= 1'b0;
         scl_oe    <= 1'b0;
         sda_oe    <= 1'b0;
         byte_done <= 1'b0;
         arb_lost  <= 1'b0;
         nack      <= 1'b0;
         rx_byte   <= '0;
      end else begin
         byte_done <= 1'b0;
         arb_lost  <= 1'b0;
         if (!en) begin
            state  <= ST_IDLE;
            phase  <= '0;
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  scl_oe <= 1'b0;
                  sda_oe <= 1'b0;
                  if (msta && !bus_busy) begin
                     state <= ST_START;
                     phase <= '0;
                  end
               end
               ST_START: if (tick) begin
                  if (phase == 2'd0) begin
                     sda_oe <= 1'b1;
                     phase  <= 2'd1;
                  end else begin
                     scl_oe <= 1'b1;
                     phase  <= '0;
                     state  <= ST_HOLD;
                  end
               end
               ST_HOLD: begin
                  phase <= '0;
                  bitn  <= '0;
                  if (!msta) begin
                     state <= ST_STOP;
                  end else if (tx_go && tx_dir) begin
                     state   <= ST_BYTE;
                     shreg   <= tx_byte;
                     rx_mode <= 1'b0;
                  end else if (rx_go && !tx_dir) begin
                     state   <= ST_BYTE;
                     rx_mode <= 1'b1;
                  end
               end
               ST_BYTE: if (tick) begin
                  phase <= phase + 1'b1;
                  unique case (phase)
                     2'd0: sda_oe <= drive_low;
                     2'd1: scl_oe <= 1'b0;
                     2'd2: begin
                        if (bitn == ACK_SLOT) begin
                           if (!rx_mode) nack <= sda_in;
                        end else if (rx_mode) begin
                           shreg <= {shreg[BYTE_W-2:0], sda_in};
                        end else if (!sda_oe && !sda_in) begin
                           arb_lost <= 1'b1;
                           scl_oe   <= 1'b0;
                           sda_oe   <= 1'b0;
                           state    <= ST_IDLE;
                        end else begin
                           shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        end
                     end
                     default: begin
                        scl_oe <= 1'b1;
                        if (bitn == ACK_SLOT) begin
                           byte_done <= 1'b1;
                           state     <= ST_HOLD;
                           if (rx_mode) rx_byte <= shreg;
                        end else begin
                           bitn <= bitn + 1'b1;
                        end
                     end
                  endcase
               end
               ST_STOP: if (tick) begin
                  phase <= phase + 1'b1;
                  if (phase == 2'd0)      sda_oe <= 1'b1;
                  else if (phase == 2'd1) scl_oe <= 1'b0;
                  else begin
                     sda_oe <= 1'b0;
                     state  <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl
   import i2c_host_pkg::*;
#(
   parameter int DIV_W = 16,
   parameter int MIN_Q = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              scl_oe,
   input  logic              scl_in,
   output logic              sda_oe,
   input  logic              sda_in
);
   generate
      if (MIN_Q < 4) begin : g_bad_q
         $error("i2c_host_ctrl: quarter period floor below 4 clocks");
      end
   endgenerate

   logic [CTL_W-1:0]  ctl;
   logic [DIV_W-1:0]  div;
   logic [BYTE_W-1:0] rx_byte;
   logic pend, sts_wr, tx_go, rx_go;
   logic run, tick, bus_busy, byte_done, arb_lost, nack;
   logic ctl_en, ctl_msta;

   assign ctl_en   = ctl[CB_EN];
   assign ctl_msta = ctl[CB_MST];
   assign irq      = pend && ctl[CB_IE];

   i2c_host_regs #(.DIV_W(DIV_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .byte_done(byte_done), .arb_lost(arb_lost), .nack(nack),
      .bus_busy(bus_busy), .rx_byte(rx_byte),
      .ctl(ctl), .div(div), .pend(pend), .sts_wr(sts_wr),
      .tx_go(tx_go), .rx_go(rx_go)
   );

   i2c_host_qtick #(.DIV_W(DIV_W), .MIN_Q(MIN_Q)) u_qtick (
      .clk(clk), .rst_n(rst_n), .run(run), .div(div), .tick(tick)
   );

   i2c_host_busmon u_busmon (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .bus_busy(bus_busy)
   );

   i2c_host_engine u_engine (
      .clk(clk), .rst_n(rst_n),
      .en(ctl_en), .msta(ctl_msta), .tx_dir(ctl[CB_TX]), .tx_nak(ctl[CB_NAK]),
      .tx_go(tx_go), .rx_go(rx_go), .tx_byte(bus_wdata[BYTE_W-1:0]),
      .tick(tick), .bus_busy(bus_busy), .sda_in(sda_in),
      .run(run), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .byte_done(byte_done), .arb_lost(arb_lost), .nack(nack),
      .rx_byte(rx_byte)
   );
endmodule

// File: rtl/i2c_host_chk.sv
module i2c_host_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic msta,
   input logic scl_oe,
   input logic sda_oe,
   input logic byte_done,
   input logic arb_lost,
   input logic pend,
   input logic sts_clr_wr
);
   // R12
   off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!scl_oe && !sda_oe));

   // R5
   pend_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> pend);

   // R9
   arb_lines_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> (!scl_oe && !sda_oe));

   // R9
   arb_drop_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |=> !msta);

   // R10
   pend_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend) |-> $past(sts_clr_wr));

   // R4
   line_stagger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((scl_oe != $past(scl_oe)) && en && !arb_lost) |-> (sda_oe == $past(sda_oe)));
endmodule

bind i2c_host_ctrl i2c_host_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en(ctl_en), .msta(ctl_msta),
   .scl_oe(scl_oe), .sda_oe(sda_oe), .byte_done(byte_done),
   .arb_lost(arb_lost), .pend(pend), .sts_clr_wr(sts_wr)
);

// File: tb/i2c_host_ctrl_tb.sv
module i2c_host_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq, m_scl_oe, m_sda_oe;
   logic        s_sda_low = 1'b0, jam = 1'b0;
   wire         scl_w = ~m_scl_oe;
   wire         sda_w = ~(m_sda_oe | s_sda_low | jam);

   int checks = 0, fails = 0;

   localparam logic [4:0] A_OWN = 5'h00, A_DIV = 5'h04, A_CTL = 5'h08,
                          A_STS = 5'h0C, A_DAT = 5'h10;
   localparam logic [15:0] C_EN = 16'h1, C_IE = 16'h2, C_MST = 16'h4,
                           C_TX = 16'h8, C_NAK = 16'h10;
   localparam logic [6:0] SLV_ADDR = 7'h50;

   always #2 clk = ~clk;

   i2c_host_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq), .scl_oe(m_scl_oe), .scl_in(scl_w),
      .sda_oe(m_sda_oe), .sda_in(sda_w)
   );

   // behavioural slave
   int         starts = 0, stops = 0, bcnt = 0, rx_count = 0, tx_idx = 0, mack_count = 0;
   logic       active = 0, addr_phase = 0, slv_tx = 0, match = 0, mack = 0;
   logic [7:0] sh = '0;
   logic [7:0] rx_log [0:7];
   logic [7:0] tx_data [0:3];
   logic       mack_log [0:3];

   always @(negedge sda_w) if (scl_w) begin
      starts++; active = 1; bcnt = 0; addr_phase = 1; slv_tx = 0; s_sda_low = 0;
   end
   always @(posedge sda_w) if (scl_w) begin
      stops++; active = 0; slv_tx = 0; s_sda_low = 0;
   end
   always @(posedge scl_w) if (active) begin
      if (bcnt < 8) sh = {sh[6:0], sda_w};
      else if (slv_tx) begin
         mack = !sda_w;
         if (mack_count < 4) mack_log[mack_count] = mack;
         mack_count++;
      end
      bcnt++;
   end
   always @(negedge scl_w) if (active) begin
      if (bcnt == 8) begin
         if (!slv_tx) begin
            if (addr_phase) begin
               match = (sh[7:1] == SLV_ADDR);
               s_sda_low = match;
            end else begin
               if (rx_count < 8) rx_log[rx_count] = sh;
               rx_count++;
               s_sda_low = 1;
            end
         end else s_sda_low = 0;
      end else if (bcnt == 9) begin
         bcnt = 0;
         if (addr_phase) begin
            addr_phase = 0;
            if (match && sh[0]) begin
               slv_tx = 1; tx_idx = 0; s_sda_low = !tx_data[0][7];
            end else s_sda_low = 0;
         end else if (slv_tx) begin
            if (mack) begin
               tx_idx = (tx_idx + 1) % 4; s_sda_low = !tx_data[tx_idx][7];
            end else begin
               slv_tx = 0; s_sda_low = 0;
            end
         end else s_sda_low = 0;
      end else if (slv_tx && bcnt > 0) begin
         s_sda_low = !tx_data[tx_idx][7-bcnt];
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1; bus_rd = 1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      while (!irq && n < 6000) begin @(negedge clk); n++; end
   endtask

   task automatic wait_pend();
      logic [15:0] s;
      s = '0;
      for (int i = 0; i < 2000; i++) begin
         rd(A_STS, s);
         if (s[1]) break;
      end
   endtask

   task automatic wait_free();
      logic [15:0] s;
      for (int i = 0; i < 2000; i++) begin
         rd(A_STS, s);
         if (!s[3]) break;
      end
   endtask

   task automatic t_reset();
      logic [15:0] v;
      for (int i = 0; i < 5; i++) begin
         rd(5'(i * 4), v);
         chk(v == 16'h0, "R1 register reset", v, 0);
      end
      chk(!m_scl_oe && !m_sda_oe, "R1 lines released", {m_scl_oe, m_sda_oe}, 0);
      chk(!irq, "R1 irq low", irq, 0);
   endtask

   task automatic t_regs();
      logic [15:0] v;
      wr(A_OWN, 16'h1234); rd(A_OWN, v);
      chk(v == 16'h1234, "R2 own address", v, 16'h1234);
      wr(A_DIV, 16'h0005); rd(A_DIV, v);
      chk(v == 16'h0005, "R2 divider", v, 5);
   endtask

   task automatic t_disabled();
      logic [15:0] v;
      int toggles;
      toggles = 0;
      wr(A_CTL, C_MST | C_TX);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (m_scl_oe || m_sda_oe) toggles++;
      end
      chk(toggles == 0, "R12 no line activity when off", toggles, 0);
      rd(A_STS, v);
      chk(v[3] == 1'b0 && starts == 0, "R12 no START when off", starts, 0);
      wr(A_CTL, 16'h0);
   endtask

   task automatic t_write();
      logic [15:0] v;
      int n;
      wr(A_CTL, C_EN | C_IE | C_TX);
      wr(A_CTL, C_EN | C_IE | C_TX | C_MST);
      repeat (30) @(negedge clk);
      rd(A_STS, v);
      chk(v[3] && starts == 1 && m_scl_oe && m_sda_oe, "R3 START and busy", {v[3], 4'(starts)}, 16'h11);
      wr(A_DAT, 16'h00A0);
      wait_irq(n);
      chk(n >= 36 * 5 && n <= 36 * 5 + 2, "R5 pending timing div 5", n, 36 * 5 + 1);
      rd(A_STS, v);
      chk(v[0] == 1'b0, "R6 address acked", v[0], 0);
      wr(A_STS, 16'h0);
      rd(A_STS, v);
      chk(v[1] == 1'b0 && !irq, "R10 R11 pending cleared", {v[1], irq}, 0);
      wr(A_DAT, 16'h003C);
      wait_irq(n);
      chk(irq, "R11 irq on pending", irq, 1);
      chk(rx_count == 1 && rx_log[0] == 8'h3C, "R4 slave got byte", rx_log[0], 8'h3C);
      wr(A_STS, 16'h0);
      wr(A_CTL, C_EN | C_IE | C_TX);
      wait_free();
      chk(stops == 1 && !m_scl_oe && !m_sda_oe, "R8 STOP issued", stops, 1);
   endtask

   task automatic t_quarter_floor();
      int n;
      wr(A_DIV, 16'h0001);
      wr(A_CTL, C_EN | C_IE | C_TX | C_MST);
      repeat (30) @(negedge clk);
      wr(A_DAT, 16'h00A0);
      wait_irq(n);
      chk(n >= 36 * 4 && n <= 36 * 4 + 2, "R5 quarter floor 4", n, 36 * 4 + 1);
      wr(A_STS, 16'h0);
      wr(A_CTL, C_EN | C_IE | C_TX);
      wait_free();
   endtask

   task automatic t_nack();
      logic [15:0] v;
      wr(A_CTL, C_EN | C_TX | C_MST);
      repeat (30) @(negedge clk);
      wr(A_DAT, 16'h0022);
      wait_pend();
      rd(A_STS, v);
      chk(v[0] == 1'b1, "R6 NACK flagged", v[0], 1);
      chk(!irq, "R11 irq masked", irq, 0);
      wr(A_STS, 16'h0);
      wr(A_CTL, C_EN | C_TX);
      wait_free();
   endtask

   task automatic t_read();
      logic [15:0] v;
      int n;
      tx_data[0] = 8'h5A; tx_data[1] = 8'hC3; tx_data[2] = 8'hFF; tx_data[3] = 8'hFF;
      mack_count = 0;
      wr(A_CTL, C_EN | C_IE | C_TX | C_MST);
      repeat (30) @(negedge clk);
      wr(A_DAT, 16'h00A1);
      wait_irq(n);
      wr(A_STS, 16'h0);
      wr(A_CTL, C_EN | C_IE | C_MST);
      rd(A_DAT, v);
      wait_irq(n);
      wr(A_STS, 16'h0);
      wr(A_CTL, C_EN | C_IE | C_MST | C_NAK);
      rd(A_DAT, v);
      chk(v[7:0] == 8'h5A, "R7 first byte", v[7:0], 8'h5A);
      wait_irq(n);
      wr(A_STS, 16'h0);
      wr(A_CTL, C_EN | C_IE);
      rd(A_DAT, v);
      chk(v[7:0] == 8'hC3, "R7 second byte", v[7:0], 8'hC3);
      wait_free();
      chk(mack_count == 2 && mack_log[0] == 1'b1, "R7 ACK on first", mack_log[0], 1);
      chk(mack_log[1] == 1'b0, "R7 NACK on last", mack_log[1], 0);
   endtask

   task automatic t_arb();
      logic [15:0] v;
      int n;
      wr(A_CTL, C_EN | C_IE | C_TX | C_MST);
      repeat (30) @(negedge clk);
      jam = 1;
      wr(A_DAT, 16'h0080);
      wait_irq(n);
      rd(A_STS, v);
      chk(v[2] && v[1], "R9 arbitration flags", v[2:1], 2'b11);
      rd(A_CTL, v);
      chk(v[2] == 1'b0, "R9 master cleared", v[2], 0);
      chk(!m_scl_oe && !m_sda_oe, "R9 lines released", {m_scl_oe, m_sda_oe}, 0);
      jam = 0;
      wait_free();
      wr(A_STS, 16'h0);
      rd(A_STS, v);
      chk(v[2:1] == 2'b00 && !irq, "R10 flags cleared", v[2:1], 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_regs();
      t_disabled();
      t_write();
      t_quarter_floor();
      t_nack();
      t_read();
      t_arb();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule